// File: doc/BRIEF.md
# Small-Footprint Platform Interrupt Controller

This block collects level-sensitive interrupt lines from a set of peripherals and presents them to a single hart as two external interrupt requests: one for machine mode and one for supervisor mode. Each target has its own enable mask. Software finds the source to service by reading that target's claim register. It signals the end of service by writing the same source number back to that register. The number of sources is a parameter and may be 8, 12, 16 or 32.

The block has one fixed priority level. Every source has priority 1 and every target threshold is 0, so any source that is pending and enabled raises the request. The comparison between the fixed priority and the threshold stays in the target logic, so the priority path disappears in synthesis. What remains is the per-source gateway state and the claim/complete handshake.

A simple register port gives access. A read takes one clock edge: the data appears on the output the cycle after the request and is zero in any cycle that follows no read. Register select values: 0 holds the pending bits, 1 the machine enable mask, 2 the supervisor enable mask, 3 the machine claim/complete register and 4 the supervisor claim/complete register. In the pending word and in both enable masks, bit i belongs to source ID i+1. ID 0 means "nothing".

Top module: `ihub_top`

## Requirements
- R1: When source line i is high, its gateway is idle and the source is not pending, bit i of the pending word (select 0) becomes 1 at the next clock edge. Source ID i+1 corresponds to line i, and ID 0 is never pending.
- R2: Writes to select 1 and select 2 store the low NSRC bits as the machine and supervisor enable masks, and reads of those selects return them.
- R3: `irq_m` is high exactly when some source is pending with its bit set in the machine mask, and `irq_s` likewise for the supervisor mask. Every source has fixed priority 1, which is above the fixed threshold 0.
- R4: A read of select 3 or 4 returns the lowest-numbered source that is pending and enabled for that target. In the same edge it clears that source's pending bit and marks the source in service.
- R5: A claim read when no source is pending and enabled for that target returns 0 and changes no pending, in-service or enable state.
- R6: A source in service does not become pending again, whatever its line does, until its ID is written to select 3 or 4. After that write, a line that is still high sets pending at the following edge.
- R7: A completion write whose value is 0, out of range, or the ID of a source not in service has no effect.
- R8: The pending word is read-only, so writes to select 0 are ignored. Reads of selects 5 to 7 return 0.
- R9: After reset, all pending, in-service and enable state is 0, both requests are low and read data is 0. Read data appears one cycle after the read request and is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lines | input | NSRC | Level interrupt lines, bit i is source ID i+1 |
| req_rd | input | 1 | Register read strobe |
| req_wr | input | 1 | Register write strobe |
| req_sel | input | 3 | Register select |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, one cycle after the read |
| irq_m | output | 1 | Machine-mode external interrupt request |
| irq_s | output | 1 | Supervisor-mode external interrupt request |

## Verification
The properties assume that a read and a write are never requested in the same cycle. Under that assumption, a read cannot disturb the in-service bits except through a successful claim. The stimulus picks one operation per cycle, either a read, a write or idle, so the strobes never overlap. Source lines change freely at any cycle, and completion values deliberately include 0, IDs not in service and out-of-range numbers.

// File: rtl/ihub_pkg.sv
package ihub_pkg;

    typedef enum logic [2:0] {
        SEL_PEND    = 3'd0,
        SEL_EN_M    = 3'd1,
        SEL_EN_S    = 3'd2,
        SEL_CLAIM_M = 3'd3,
        SEL_CLAIM_S = 3'd4
    } reg_sel_e;

    localparam int unsigned PRIO_W = 1;
    localparam logic [PRIO_W-1:0] SRC_PRIO   = 1'b1;
    localparam logic [PRIO_W-1:0] TGT_THRESH = 1'b0;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } bus_req_t;

    function automatic int unsigned id_width(int unsigned nsrc);
        return $clog2(nsrc + 1);
    endfunction

endpackage

// File: rtl/ihub_gate.sv
module ihub_gate (
    input  logic clk,
    input  logic rst,
    input  logic line,
    input  logic take,
    input  logic done,
    output logic pend,
    output logic busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            busy <= 1'b0;
        end else if (take) begin
            pend <= 1'b0;
            busy <= 1'b1;
        end else if (done && busy) begin
            busy <= 1'b0;
        end else if (line && !busy) begin
            pend <= 1'b1;
        end
    end
endmodule

// File: rtl/ihub_target.sv
module ihub_target
    import ihub_pkg::*;
#(
    parameter int unsigned NSRC = 8,
    localparam int unsigned IDW = id_width(NSRC)
) (
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] en,
    output logic            irq,
    output logic [IDW-1:0]  best_id
);
    logic [NSRC-1:0] elig;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            elig[i] = pend[i] && en[i] && (SRC_PRIO > TGT_THRESH);
        end
    end

    always_comb begin
        best_id = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) best_id = IDW'(i + 1);
        end
    end

    assign irq = |elig;
endmodule

// File: rtl/ihub_top.sv
module ihub_top
    import ihub_pkg::*;
#(
    parameter int unsigned NSRC   = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_lines,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [2:0]        req_sel,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq_m,
    output logic              irq_s
);
    localparam int unsigned IDW = id_width(NSRC);

    bus_req_t          req;
    logic [NSRC-1:0]   pend, busy, en_m, en_s, take_vec, done_vec;
    logic [IDW-1:0]    id_m, id_s;
    logic              claim_m, claim_s, complete;
    logic [DATA_W-1:0] rdata_d;

    assign req.rd  = req_rd;
    assign req.wr  = req_wr;
    assign req.sel = reg_sel_e'(req_sel);

    assign claim_m  = req.rd && (req.sel == SEL_CLAIM_M);
    assign claim_s  = req.rd && (req.sel == SEL_CLAIM_S);
    assign complete = req.wr && (req.sel == SEL_CLAIM_M || req.sel == SEL_CLAIM_S);

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            assign take_vec[g] = (claim_m && id_m == IDW'(g + 1)) ||
                                 (claim_s && id_s == IDW'(g + 1));
            assign done_vec[g] = complete && (req_wdata == DATA_W'(g + 1));
            ihub_gate gate_i (
                .clk  (clk),
                .rst  (rst),
                .line (src_lines[g]),
                .take (take_vec[g]),
                .done (done_vec[g]),
                .pend (pend[g]),
                .busy (busy[g])
            );
        end
    endgenerate

    ihub_target #(.NSRC(NSRC)) tgt_m_i (
        .pend (pend), .en (en_m), .irq (irq_m), .best_id (id_m)
    );
    ihub_target #(.NSRC(NSRC)) tgt_s_i (
        .pend (pend), .en (en_s), .irq (irq_s), .best_id (id_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_m <= '0;
            en_s <= '0;
        end else if (req.wr) begin
            if (req.sel == SEL_EN_M) en_m <= req_wdata[NSRC-1:0];
            if (req.sel == SEL_EN_S) en_s <= req_wdata[NSRC-1:0];
        end
    end

    always_comb begin
        case (req.sel)
            SEL_PEND:    rdata_d = DATA_W'(pend);
            SEL_EN_M:    rdata_d = DATA_W'(en_m);
            SEL_EN_S:    rdata_d = DATA_W'(en_s);
            SEL_CLAIM_M: rdata_d = DATA_W'(id_m);
            SEL_CLAIM_S: rdata_d = DATA_W'(id_s);
            default:     rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rsp_rdata <= '0;
        else if (req.rd) rsp_rdata <= rdata_d;
        else             rsp_rdata <= '0;
    end
endmodule

// File: rtl/ihub_chk.sv
module ihub_chk #(
    parameter int unsigned NSRC   = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_rd,
    input logic [2:0]        req_sel,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              irq_m,
    input logic              irq_s,
    input logic [NSRC-1:0]   pend,
    input logic [NSRC-1:0]   busy
);
    AST_EMPTY_CLAIM_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_rd && req_sel == 3'd3 && !irq_m) |=> rsp_rdata == '0); // R5

    AST_EMPTY_CLAIM_KEEPS_SERVICE: assert property (@(posedge clk) disable iff (rst)
        (req_rd && ((req_sel == 3'd3 && !irq_m) || (req_sel == 3'd4 && !irq_s)))
        |=> $stable(busy)); // R5

    AST_CLAIM_RETURNS_ID: assert property (@(posedge clk) disable iff (rst)
        (req_rd && req_sel == 3'd3 && irq_m)
        |=> (rsp_rdata != '0 && rsp_rdata <= DATA_W'(NSRC))); // R4

    AST_CLAIM_MARKS_SERVICE: assert property (@(posedge clk) disable iff (rst)
        (req_rd && req_sel == 3'd4 && irq_s)
        |=> $countones(busy) == $past($countones(busy)) + 1); // R4

    AST_SERVICE_BLOCKS_PEND: assert property (@(posedge clk) disable iff (rst)
        (pend & ~$past(pend) & $past(busy)) == '0); // R6

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !req_rd |=> rsp_rdata == '0); // R9
endmodule

bind ihub_top ihub_chk #(.NSRC(NSRC), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_rd    (req_rd),
    .req_sel   (req_sel),
    .rsp_rdata (rsp_rdata),
    .irq_m     (irq_m),
    .irq_s     (irq_s),
    .pend      (pend),
    .busy      (busy)
);

// File: tb/ihub_top_tb_top.sv
module ihub_top_tb_top;
    localparam int NSRC = 8;
    localparam int DW   = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_lines = '0;
    logic            req_rd = 1'b0, req_wr = 1'b0;
    logic [2:0]      req_sel = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic [DW-1:0]   rsp_rdata;
    logic            irq_m, irq_s;

    ihub_top #(.NSRC(NSRC), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .src_lines(src_lines), .req_rd(req_rd),
        .req_wr(req_wr), .req_sel(req_sel), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .irq_m(irq_m), .irq_s(irq_s)
    );

    always #10 clk = ~clk;

    logic [NSRC-1:0] m_pend = '0, m_busy = '0, m_en_m = '0, m_en_s = '0;
    logic [DW-1:0]   m_rdata = '0;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int low_id(logic [NSRC-1:0] v);
        for (int i = 0; i < NSRC; i++) if (v[i]) return i + 1;
        return 0;
    endfunction

    function automatic string tag_of(logic rd, logic [2:0] sel);
        if (!rd) return "R9 idle rdata";
        case (sel)
            3'd0: return "R1 pending read";
            3'd1, 3'd2: return "R2 enable read";
            3'd3, 3'd4: return "R4/R5 claim read";
            default: return "R8 unmapped read";
        endcase
    endfunction

    // expected state after the coming edge, from the requirements
    task automatic model_step();
        logic [NSRC-1:0] taken = '0;
        int id;
        m_rdata = '0;
        if (req_rd) begin
            case (req_sel)
                3'd0: m_rdata = DW'(m_pend);
                3'd1: m_rdata = DW'(m_en_m);
                3'd2: m_rdata = DW'(m_en_s);
                3'd3, 3'd4: begin
                    id = low_id(m_pend & (req_sel == 3'd3 ? m_en_m : m_en_s));
                    m_rdata = DW'(id);
                    if (id != 0) taken[id-1] = 1'b1;
                end
                default: m_rdata = '0;
            endcase
        end
        for (int i = 0; i < NSRC; i++) begin
            if (taken[i]) begin
                m_pend[i] = 1'b0;
                m_busy[i] = 1'b1;
            end else if (req_wr && (req_sel == 3'd3 || req_sel == 3'd4) &&
                         req_wdata == DW'(i + 1) && m_busy[i]) begin
                m_busy[i] = 1'b0;
            end else if (src_lines[i] && !m_busy[i]) begin
                m_pend[i] = 1'b1;
            end
        end
        if (req_wr && req_sel == 3'd1) m_en_m = req_wdata[NSRC-1:0];
        if (req_wr && req_sel == 3'd2) m_en_s = req_wdata[NSRC-1:0];
    endtask

    task automatic cycle(logic rd, logic wr, logic [2:0] sel, logic [DW-1:0] wd, string tag);
        string t;
        req_rd = rd; req_wr = wr; req_sel = sel; req_wdata = wd;
        model_step();
        t = (tag == "") ? tag_of(rd, sel) : tag;
        @(negedge clk);
        req_rd = 1'b0; req_wr = 1'b0;
        chk(t, rsp_rdata, m_rdata);
        chk("R3 irq_m", DW'(irq_m), DW'(|(m_pend & m_en_m)));
        chk("R3 irq_s", DW'(irq_s), DW'(|(m_pend & m_en_s)));
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset rdata", rsp_rdata, '0);
        chk("R9 reset irq", DW'({irq_m, irq_s}), '0);
        cycle(1, 0, 3'd0, '0, "R9 reset pending");
        cycle(1, 0, 3'd1, '0, "R9 reset enable");

        src_lines = 8'b0010_0100;                      // IDs 3 and 6
        cycle(0, 0, 3'd0, '0, "");
        cycle(1, 0, 3'd0, '0, "R1 pending 3 and 6");
        cycle(1, 0, 3'd3, '0, "R5 claim with mask empty");
        cycle(0, 1, 3'd1, 32'hFF, "");
        cycle(1, 0, 3'd1, '0, "R2 enable readback");
        cycle(1, 0, 3'd3, '0, "R4 lowest claim is 3");
        cycle(1, 0, 3'd0, '0, "R6 claimed source not re-pending");
        cycle(1, 0, 3'd4, '0, "R5 supervisor claim empty");
        cycle(0, 1, 3'd3, 32'd6, "");                  // 6 not in service
        cycle(0, 1, 3'd4, 32'd0, "");
        cycle(0, 1, 3'd3, 32'd40, "");
        cycle(1, 0, 3'd0, '0, "R7 bad completions ignored");
        cycle(0, 1, 3'd3, 32'd3, "");
        cycle(0, 0, 3'd0, '0, "");
        cycle(1, 0, 3'd0, '0, "R6 re-pend after completion");
        cycle(0, 1, 3'd0, '0, "");
        cycle(1, 0, 3'd0, '0, "R8 pending write ignored");
        cycle(1, 0, 3'd7, '0, "R8 unmapped read zero");

        for (int n = 0; n < 4000; n++) begin
            int op;
            if ($urandom % 4 == 0) src_lines = NSRC'($urandom);
            op = $urandom % 8;
            case (op)
                0, 1: cycle(1, 0, 3'd3, '0, "");
                2:    cycle(1, 0, 3'd4, '0, "");
                3:    cycle(0, 1, 3'(3 + $urandom % 2), DW'($urandom % (NSRC + 3)), "");
                4:    cycle(0, 1, 3'd1, DW'($urandom), "");
                5:    cycle(0, 1, 3'd2, DW'($urandom), "");
                6:    cycle(1, 0, 3'($urandom), '0, "");
                default: cycle(0, 0, 3'd0, '0, "");
            endcase
        end
        finished = 1;
        report();
    end
endmodule